// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level page table held in ordinary memory. A request carries the virtual address and a flag that marks the access as a store. The walker first reads the top-level entry, using a root frame number supplied from a control register. It then reads the leaf entry that the top-level entry points to. Finally it answers with either a physical address or a page fault.

All table reads go through a single-word request/response memory port, and only one walk is in flight at a time. When a walk succeeds, the walker records the reference in the leaf entry itself. It sets the referenced bit, and for a store also the modified bit, using a read-modify-write. The write-back is issued only when one of those bits actually changes. Software sees a fault whenever either level holds an entry without its present bit.

Entry layout used throughout: bit 0 present, bit 1 referenced, bit 2 modified, bits 31:12 the frame number (the next table's frame for a top-level entry, the data page's frame for a leaf). Bits 11:3 carry no meaning to the walker and are preserved on write-back.

Top module: `ptw_walker`

## Requirements
- R1: The first memory read of a walk is a read of address {root_frame, vaddr[31:22], 2'b00}. The root frame and the virtual address are captured when the request is accepted.
- R2: When the top-level entry is present, the second read is of address {entry[31:12], vaddr[21:12], 2'b00}.
- R3: A top-level entry with bit 0 clear ends the walk with rsp_fault=1 and rsp_paddr=0. No further read and no write is issued.
- R4: A leaf entry with bit 0 clear ends the walk with rsp_fault=1 and rsp_paddr=0. No write is issued.
- R5: A successful walk answers rsp_fault=0 and rsp_paddr={leaf[31:12], vaddr[11:0]}.
- R6: After a successful load walk whose leaf has bit 1 clear, exactly one write goes to the leaf address. Its data is the leaf with bit 1 set and all other bits unchanged.
- R7: After a successful store walk whose leaf lacks bit 1 or bit 2, exactly one write goes to the leaf address. Its data is the leaf with bits 1 and 2 both set and all other bits unchanged.
- R8: No write is issued when the leaf already holds every bit the access would set: bit 1 for a load, bits 1 and 2 for a store.
- R9: req_ready is low from the accepting edge until the response handshake completes. A request held during that time starts no second walk.
- R10: rsp_valid, rsp_fault and rsp_paddr hold steady until rsp_ready is seen high.
- R11: A memory request, with its address, write flag and data, holds steady until mem_req_ready is seen high. The memory port is quiet while the walker is idle.
- R12: After reset, req_ready=1, rsp_valid=0 and mem_req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_frame | input | 20 | Frame number of the top-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a store |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_fault | output | 1 | Page fault |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Word byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The assertions assume that memory returns exactly one read response for each accepted read, never before that acceptance and never for a write. They also assume it sends nothing while the walker is not waiting for data. The bench memory model keeps to this by answering each accepted read one cycle later and answering writes with nothing. Its acceptance signal stalls in a pseudo-random pattern, so the hold-until-accepted rules are exercised. Requesters keep the request inputs steady only while they wait for acceptance. The bench also changes the address of a request that is deliberately held during a walk, to show that the captured copy is the one used.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int FRAME_W = VA_W - OFF_W;
  localparam int PTE_W   = 32;
  localparam int BIT_PRESENT = 0;
  localparam int BIT_REF     = 1;
  localparam int BIT_MOD     = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_RD, ST_L1_WT, ST_L2_RD, ST_L2_WT, ST_WB, ST_RSP
  } walk_st_e;

  function automatic logic [IDX_W-1:0] top_index(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] leaf_index(input logic [VA_W-1:0] va);
    return va[OFF_W +: IDX_W];
  endfunction

  function automatic logic [OFF_W-1:0] page_offset(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  function automatic logic [VA_W-1:0] slot_addr(input logic [FRAME_W-1:0] frame,
                                                input logic [IDX_W-1:0] idx);
    return {frame, idx, 2'b00};
  endfunction

  function automatic logic [FRAME_W-1:0] entry_frame(input logic [PTE_W-1:0] pte);
    return pte[PTE_W-1 -: FRAME_W];
  endfunction

  function automatic logic [PTE_W-1:0] mark_entry(input logic [PTE_W-1:0] pte,
                                                 input logic store);
    logic [PTE_W-1:0] r;
    r = pte;
    r[BIT_REF] = 1'b1;
    if (store) r[BIT_MOD] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_fire,
  input  logic     mem_req_ready,
  input  logic     mem_rsp_valid,
  input  logic     entry_present,
  input  logic     leaf_changes,
  input  logic     rsp_ready,
  output walk_st_e state
);
  walk_st_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (req_fire) nxt = ST_L1_RD;
      ST_L1_RD: if (mem_req_ready) nxt = ST_L1_WT;
      ST_L1_WT: if (mem_rsp_valid) nxt = entry_present ? ST_L2_RD : ST_RSP;
      ST_L2_RD: if (mem_req_ready) nxt = ST_L2_WT;
      ST_L2_WT: if (mem_rsp_valid) begin
        if (entry_present && leaf_changes) nxt = ST_WB;
        else nxt = ST_RSP;
      end
      ST_WB:    if (mem_req_ready) nxt = ST_RSP;
      ST_RSP:   if (rsp_ready) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/ptw_addr_sel.sv
module ptw_addr_sel
  import ptw_pkg::*;
(
  input  walk_st_e           state,
  input  logic [FRAME_W-1:0] root_q,
  input  logic [FRAME_W-1:0] l1_frame_q,
  input  logic [VA_W-1:0]    va_q,
  output logic [VA_W-1:0]    addr
);
  always_comb begin
    if (state == ST_L1_RD) addr = slot_addr(root_q, top_index(va_q));
    else                   addr = slot_addr(l1_frame_q, leaf_index(va_q));
  end
endmodule

// File: rtl/ptw_leaf_upd.sv
module ptw_leaf_upd
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] leaf,
  input  logic             store,
  output logic [PTE_W-1:0] new_leaf,
  output logic             changed
);
  always_comb begin
    new_leaf = mark_entry(leaf, store);
    changed  = (new_leaf != leaf);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] root_frame,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault,
  output logic [VA_W-1:0]    rsp_paddr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_we,
  output logic [VA_W-1:0]    mem_req_addr,
  output logic [PTE_W-1:0]   mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_rdata
);
  walk_st_e           state;
  logic [VA_W-1:0]    va_q;
  logic               walk_wr;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] l1_frame_q;
  logic [PTE_W-1:0]   leaf_new_q;
  logic               fault_q;
  logic [PTE_W-1:0]   upd_leaf;
  logic               upd_changed;
  logic               walk_start;
  logic               l1_done;
  logic               l2_done;
  logic               rd_present;

  assign req_ready  = (state == ST_IDLE);
  assign walk_start = req_valid && req_ready;
  assign l1_done    = (state == ST_L1_WT) && mem_rsp_valid;
  assign l2_done    = (state == ST_L2_WT) && mem_rsp_valid;
  assign rd_present = mem_rsp_rdata[BIT_PRESENT];

  ptw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_fire      (walk_start),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .entry_present (rd_present),
    .leaf_changes  (upd_changed),
    .rsp_ready     (rsp_ready),
    .state         (state)
  );

  ptw_addr_sel u_addr (
    .state      (state),
    .root_q     (root_q),
    .l1_frame_q (l1_frame_q),
    .va_q       (va_q),
    .addr       (mem_req_addr)
  );

  ptw_leaf_upd u_upd (
    .leaf     (mem_rsp_rdata),
    .store    (walk_wr),
    .new_leaf (upd_leaf),
    .changed  (upd_changed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q       <= '0;
      walk_wr    <= 1'b0;
      root_q     <= '0;
      l1_frame_q <= '0;
      leaf_new_q <= '0;
      fault_q    <= 1'b0;
    end else begin
      if (walk_start) begin
        va_q    <= req_vaddr;
        walk_wr <= req_write;
        root_q  <= root_frame;
        fault_q <= 1'b0;
      end
      if (l1_done) begin
        l1_frame_q <= entry_frame(mem_rsp_rdata);
        if (!rd_present) fault_q <= 1'b1;
      end
      if (l2_done) begin
        leaf_new_q <= upd_leaf;
        if (!rd_present) fault_q <= 1'b1;
      end
    end
  end

  assign mem_req_valid = (state == ST_L1_RD) || (state == ST_L2_RD) || (state == ST_WB);
  assign mem_req_we    = (state == ST_WB);
  assign mem_req_wdata = leaf_new_q;
  assign rsp_valid     = (state == ST_RSP);
  assign rsp_fault     = fault_q;
  assign rsp_paddr     = fault_q ? '0 : {entry_frame(leaf_new_q), page_offset(va_q)};
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
  import ptw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_fault,
  input logic [VA_W-1:0]  rsp_paddr,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_we,
  input logic [VA_W-1:0]  mem_req_addr,
  input logic [PTE_W-1:0] mem_req_wdata,
  input logic [PTE_W-1:0] mem_rsp_rdata,
  input logic             l1_done,
  input logic             l2_done,
  input logic             walk_wr
);
  AST_BUSY_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R9
  AST_BUSY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault) && $stable(rsp_paddr)); // R10
  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we)
      && $stable(mem_req_addr) && $stable(mem_req_wdata)); // R11
  AST_TOP_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    l1_done && !mem_rsp_rdata[BIT_PRESENT] |=> rsp_valid && rsp_fault && !mem_req_valid); // R3
  AST_LEAF_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    l2_done && !mem_rsp_rdata[BIT_PRESENT] |=> rsp_valid && rsp_fault && !mem_req_valid); // R4
  AST_WB_REF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[BIT_REF] && mem_req_wdata[BIT_PRESENT]); // R6
  AST_WB_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we && walk_wr |-> mem_req_wdata[BIT_MOD]); // R7
  AST_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    l2_done && mem_rsp_rdata[BIT_PRESENT] && mem_rsp_rdata[BIT_REF]
      && (!walk_wr || mem_rsp_rdata[BIT_MOD]) |=> rsp_valid && !mem_req_valid); // R8
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_fault     (rsp_fault),
  .rsp_paddr     (rsp_paddr),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_rdata (mem_rsp_rdata),
  .l1_done       (l1_done),
  .l2_done       (l2_done),
  .walk_wr       (walk_wr)
);

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] root_frame = 20'h00010;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic [31:0] rsp_paddr;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit in_walk = 0;
  bit stall_en = 0;
  logic [7:0] lfsr = 8'h5a;
  logic [31:0] mem [int unsigned];
  logic [31:0] rd_log[$];
  logic [31:0] wr_addr_log[$];
  logic [31:0] wr_data_log[$];
  int rsp_count = 0;

  always #2.5 clk = ~clk;

  ptw_walker u_ptw_walker (
    .clk(clk), .rst_n(rst_n), .root_frame(root_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: reads answered one cycle after acceptance, writes silent
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr] = mem_req_wdata;
        wr_addr_log.push_back(mem_req_addr);
        wr_data_log.push_back(mem_req_wdata);
      end else begin
        rd_log.push_back(mem_req_addr);
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= peek(mem_req_addr);
      end
    end
    if (rst_n && rsp_valid && rsp_ready) rsp_count++;
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= stall_en ? lfsr[0] : 1'b1;
  end

  // per-cycle comparison while no walk is in progress
  always @(negedge clk) begin
    if (rst_n && !in_walk) begin
      checks++;
      if (!(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0)) begin
        errors++;
        $display("FAIL R11/R12 idle ports actual=%b%b%b expected=100",
                 req_ready, rsp_valid, mem_req_valid);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic walk(input logic [31:0] va, input bit wr, input bit hold, input int rsp_delay,
                      input string tag);
    logic [31:0] a1, e1, a2, e2, nl, exp_pa;
    bit exp_fault, exp_wb;
    int exp_reads;
    a1 = {root_frame, va[31:22], 2'b00};
    e1 = peek(a1);
    a2 = {e1[31:12], va[21:12], 2'b00};
    e2 = peek(a2);
    nl = e2 | 32'h2 | (wr ? 32'h4 : 32'h0);
    exp_fault = !e1[0] || !e2[0];
    exp_reads = e1[0] ? 2 : 1;
    exp_wb = !exp_fault && (nl != e2);
    exp_pa = exp_fault ? 32'h0 : {e2[31:12], va[11:0]};
    rd_log.delete(); wr_addr_log.delete(); wr_data_log.delete();
    rsp_count = 0;
    @(negedge clk);
    in_walk = 1;
    req_vaddr = va; req_write = wr; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (hold) req_vaddr = 32'hffff_ffff;
    else req_valid = 0;
    while (!rsp_valid) begin
      if (hold) check("R9 ready low while busy", {31'b0, req_ready}, 32'h0);
      @(negedge clk);
    end
    req_valid = 0;
    for (int i = 0; i < rsp_delay; i++) begin
      @(negedge clk);
      check("R10 response held", {31'b0, rsp_valid}, 32'h1);
    end
    check({"R3/R4 fault ", tag}, {31'b0, rsp_fault}, {31'b0, exp_fault});
    check({"R5 paddr ", tag}, rsp_paddr, exp_pa);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    in_walk = 0;
    check({"R9 one response ", tag}, rsp_count, 1);
    check({"R1/R2/R3 read count ", tag}, rd_log.size(), exp_reads);
    if (rd_log.size() > 0) check({"R1 top slot ", tag}, rd_log[0], a1);
    if (rd_log.size() > 1) check({"R2 leaf slot ", tag}, rd_log[1], a2);
    check({"R6/R7/R8 write count ", tag}, wr_addr_log.size(), exp_wb ? 1 : 0);
    if (exp_wb && wr_addr_log.size() == 1) begin
      check({"R6/R7 write addr ", tag}, wr_addr_log[0], a2);
      check({"R6/R7 write data ", tag}, wr_data_log[0], nl);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12 req_ready reset", {31'b0, req_ready}, 32'h1);
    check("R12 rsp_valid reset", {31'b0, rsp_valid}, 32'h0);
    check("R12 mem_req_valid reset", {31'b0, mem_req_valid}, 32'h0);
    rst_n = 1;
    // tables: top at frame 0x00010, leaf tables at frames 0x00020 and 0x00030
    mem[{20'h00010, 10'd3, 2'b00}] = 32'h0002_0001;
    mem[{20'h00010, 10'd7, 2'b00}] = 32'h0003_0001;
    mem[{20'h00020, 10'd4, 2'b00}] = 32'h0ABC_D021; // present, spare bit 5
    mem[{20'h00020, 10'd9, 2'b00}] = 32'h0123_4000; // not present
    mem[{20'h00030, 10'd1, 2'b00}] = 32'h0777_7101;
    mem[{20'h00030, 10'd2, 2'b00}] = 32'h0555_5003; // referenced already
    walk({10'd5, 10'd0, 12'h123}, 0, 0, 0, "top absent");             // R3
    walk({10'd3, 10'd9, 12'h456}, 0, 0, 0, "leaf absent");            // R4
    walk({10'd3, 10'd4, 12'h9ab}, 0, 0, 0, "load sets ref");          // R5 R6
    walk({10'd3, 10'd4, 12'h001}, 0, 0, 0, "load no wb");             // R8
    walk({10'd3, 10'd4, 12'hfff}, 1, 0, 0, "store sets mod");         // R7
    walk({10'd3, 10'd4, 12'h010}, 1, 0, 0, "store no wb");            // R8
    walk({10'd3, 10'd9, 12'h456}, 1, 0, 0, "store leaf absent");      // R4
    stall_en = 1;
    walk({10'd7, 10'd1, 12'h3c0}, 1, 1, 3, "fresh store stalled");    // R7 R9 R10 R11
    walk({10'd7, 10'd2, 12'h044}, 0, 1, 2, "ref set load stalled");   // R8 R9 R10
    walk({10'd7, 10'd2, 12'h088}, 1, 0, 1, "ref set store stalled");  // R7
    root_frame = 20'h00020;
    walk({10'd4, 10'd0, 12'h000}, 0, 0, 0, "new root");               // R1
    stall_en = 0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule